// File: doc/BRIEF.md
# UART FIFO Threshold and Flow-Control Controller

This block decides when a UART's receive and transmit FIFOs are "full enough" or "empty enough" to interrupt the host. It also runs the automatic request-to-send / clear-to-send handshake against those same fill levels. It reads the live fill counts of both FIFOs, a pair of 2-bit trigger-select fields, four 8-bit extended level registers, the flow-control enables and the incoming clear-to-send line. From these it produces the trigger flags, the outgoing flow-control pin, a transmit-pause request, a sticky CTS-change interrupt and a one-cycle flush strobe for both FIFOs.

The four extended level registers pick the operating mode. While all four are zero, the FIFOs are treated as 32 deep and every threshold comes from a fixed table indexed by the select fields. As soon as any one of them is nonzero, the FIFOs are treated as 128 deep and the register values are used directly as thresholds. A change of mode, or a toggle of the FIFO enable, flushes both FIFOs.

Top module: `fc_threshold_ctrl`

## Requirements
- R1: The mode is extended (depth 128) when any of tx_lvl, rx_lvl, flow_hi or flow_lo is nonzero. In that mode rx_trig_o = (rx_count >= rx_lvl) and tx_trig_o = (tx_count <= tx_lvl). Otherwise the mode is legacy (depth 32).
- R2: In legacy mode the RX trigger level for rx_sel = 0,1,2,3 is 8,16,24,28, and the TX trigger level for tx_sel = 0,1,2,3 is 16,8,24,30.
- R3: In legacy mode with auto_rts_en = 1, the flow line goes to 1 on the clock after rx_count >= the RX table level. It goes back to 0 on the clock after rx_count <= 0,7,15,23 (for rx_sel = 0..3). At counts in between it holds its value.
- R4: In extended mode with auto_rts_en = 1, the flow line goes to 1 on the clock after rx_count >= flow_hi. It goes to 0 on the clock after rx_count <= flow_lo, and holds its value in between. The high mark takes precedence.
- R5: flush_o is high for exactly one cycle, on the clock after fifo_en changes value or the mode of R1 changes. A change of either one while in reset counts from the reset values fifo_en = 0 and legacy mode.
- R6: With auto_cts_en = 1 and cts_irq_en = 1, a 0-to-1 change of the selected CTS line sets cts_irq_o on the next clock. The flag stays set until a cts_irq_clr cycle in which no new rising edge occurs. With auto_cts_en = 1, tx_pause_o rises on the clock after the CTS line is 1 and tx_idle_i = 1, and it stays high while the line stays 1. It drops on the clock after the line returns to 0.
- R7: rx_full_o is 1 exactly when rx_count equals the current depth (32 or 128). The flow line does not affect it.
- R8: With pin_remap = 1, dsr_i replaces cts_i as the CTS source, the flow line is driven on dtr_o, and rts_o is held at 0. With pin_remap = 0, the flow line is driven on rts_o and dtr_o is held at 0.
- R9: auto_rts_en = 0 holds the flow line at 0 whatever the RX count. auto_cts_en = 0 holds tx_pause_o at 0 and blocks new interrupt sets. Each enable works independently of the other.
- R10: Trigger flags are combinational on the counts: rx_trig_o is 1 at rx_count equal to the RX level, and tx_trig_o is 1 at tx_count equal to the TX level.
- R11: After reset the flow line, tx_pause_o, cts_irq_o and flush_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_count | input | 8 | Receive FIFO fill count |
| tx_count | input | 8 | Transmit FIFO fill count |
| fifo_en | input | 1 | FIFO enable bit |
| rx_sel | input | 2 | Legacy RX trigger select |
| tx_sel | input | 2 | Legacy TX trigger select |
| tx_lvl | input | 8 | Extended TX trigger level |
| rx_lvl | input | 8 | Extended RX trigger level |
| flow_hi | input | 8 | Extended flow-off mark |
| flow_lo | input | 8 | Extended flow-on mark |
| auto_rts_en | input | 1 | Enable automatic RTS |
| auto_cts_en | input | 1 | Enable automatic CTS |
| cts_irq_en | input | 1 | Enable CTS-change interrupt |
| cts_irq_clr | input | 1 | Clear CTS-change interrupt |
| pin_remap | input | 1 | Use DSR/DTR instead of CTS/RTS |
| cts_i | input | 1 | Clear-to-send input (1 = stop) |
| dsr_i | input | 1 | Data-set-ready input |
| tx_idle_i | input | 1 | Transmitter between characters (stop bit done) |
| rx_trig_o | output | 1 | RX trigger reached |
| tx_trig_o | output | 1 | TX trigger reached |
| rts_o | output | 1 | RTS pin (1 = negated) |
| dtr_o | output | 1 | DTR pin (1 = negated) |
| tx_pause_o | output | 1 | Request to pause transmission |
| cts_irq_o | output | 1 | CTS-change interrupt flag |
| flush_o | output | 1 | One-cycle flush of both FIFOs |
| rx_full_o | output | 1 | RX FIFO at full depth |

## Verification
The trigger flags and rx_full_o follow the counts and level inputs in the same cycle. The flow line, tx_pause_o, cts_irq_o and flush_o each appear exactly one clock after the input condition that causes them. The bench drives inputs on the falling edge and samples every output on the next falling edge. The combinational results are compared against the inputs applied half a cycle earlier. The registered results are compared against a behavioural model that advances once on the rising edge in between, so each one is checked in exactly the cycle it is due.

// File: rtl/uart_fc_pkg.sv
// Shared width and legacy threshold tables for the FIFO threshold controller.
package uart_fc_pkg;
    parameter int FC_W = 8;
    typedef logic [FC_W-1:0] lvl_t;

    typedef struct packed {
        lvl_t rx_trig;
        lvl_t tx_trig;
        lvl_t flow_hi;
        lvl_t flow_lo;
    } levels_t;

    // Legacy RX trigger / flow-off level per select code.
    function automatic lvl_t leg_rx(input logic [1:0] sel);
        case (sel)
            2'd0:    return lvl_t'(8);
            2'd1:    return lvl_t'(16);
            2'd2:    return lvl_t'(24);
            default: return lvl_t'(28);
        endcase
    endfunction

    // Legacy TX trigger level per select code.
    function automatic lvl_t leg_tx(input logic [1:0] sel);
        case (sel)
            2'd0:    return lvl_t'(16);
            2'd1:    return lvl_t'(8);
            2'd2:    return lvl_t'(24);
            default: return lvl_t'(30);
        endcase
    endfunction

    // Legacy flow-on level per select code.
    function automatic lvl_t leg_lo(input logic [1:0] sel);
        case (sel)
            2'd0:    return lvl_t'(0);
            2'd1:    return lvl_t'(7);
            2'd2:    return lvl_t'(15);
            default: return lvl_t'(23);
        endcase
    endfunction
endpackage

// File: rtl/fc_level_sel.sv
// Level selector: decides legacy or extended mode and produces the four
// thresholds and the effective depth. Purely combinational.
// Assumes the extended registers are already held stable by the bus block.
module fc_level_sel
    import uart_fc_pkg::*;
#(
    parameter int LEG_DEPTH = 32,
    parameter int EXT_DEPTH = 128
) (
    input  logic [1:0] rx_sel,
    input  logic [1:0] tx_sel,
    input  lvl_t       tx_lvl,
    input  lvl_t       rx_lvl,
    input  lvl_t       flow_hi,
    input  lvl_t       flow_lo,
    output logic       ext_mode,
    output levels_t    lv,
    output lvl_t       depth
);
    // Mode decode: any nonzero extended register selects the deep mode.
    always_comb begin
        ext_mode = (tx_lvl != '0) || (rx_lvl != '0) || (flow_hi != '0) || (flow_lo != '0);
    end

    // Threshold mux between the legacy table and the registers.
    always_comb begin
        if (ext_mode) begin
            lv.rx_trig = rx_lvl;
            lv.tx_trig = tx_lvl;
            lv.flow_hi = flow_hi;
            lv.flow_lo = flow_lo;
            depth      = lvl_t'(EXT_DEPTH);
        end else begin
            lv.rx_trig = leg_rx(rx_sel);
            lv.tx_trig = leg_tx(tx_sel);
            lv.flow_hi = leg_rx(rx_sel);
            lv.flow_lo = leg_lo(rx_sel);
            depth      = lvl_t'(LEG_DEPTH);
        end
    end

    // Legacy mode must always report the fixed table values.
    always_comb begin
        if (!ext_mode) begin
            assert_legacy_hi_R2: assert (lv.flow_hi > lv.flow_lo);
        end
    end
endmodule

// File: rtl/fc_flush_gen.sv
// Flush generator: pulses one cycle after the FIFO enable or the mode changes.
// Assumes synchronous inputs.
module fc_flush_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_en,
    input  logic ext_mode,
    output logic flush_o
);
    logic en_q, ext_q, flush_q, past_ok;

    // Remember the previous enable and mode; register the change strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            ext_q   <= 1'b0;
            flush_q <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            en_q    <= fifo_en;
            ext_q   <= ext_mode;
            flush_q <= (fifo_en != en_q) || (ext_mode != ext_q);
            past_ok <= 1'b1;
        end
    end

    assign flush_o = flush_q;

    assert_flush_on_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (fifo_en != $past(fifo_en))) |=> flush_o);
    assert_flush_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $stable(fifo_en) && $stable(ext_mode)) |=> !flush_o);
endmodule

// File: rtl/fc_rts_ctrl.sv
// RTS hysteresis: negates the flow line at the high mark and re-asserts it
// at the low mark, holding between them. Assumes hi > lo in normal use; if
// not, the high mark wins.
module fc_rts_ctrl
    import uart_fc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_rts_en,
    input  lvl_t rx_count,
    input  lvl_t mark_hi,
    input  lvl_t mark_lo,
    output logic flow_o
);
    logic flow_q;

    // Hysteresis state register.
    always_ff @(posedge clk) begin
        if (!rst_n)                   flow_q <= 1'b0;
        else if (!auto_rts_en)        flow_q <= 1'b0;
        else if (rx_count >= mark_hi) flow_q <= 1'b1;
        else if (rx_count <= mark_lo) flow_q <= 1'b0;
    end

    assign flow_o = flow_q;

    assert_rts_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && rx_count >= mark_hi) |=> flow_o);
    assert_rts_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && rx_count < mark_hi && rx_count <= mark_lo) |=> !flow_o);
    assert_rts_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && rx_count < mark_hi && rx_count > mark_lo) |=> $stable(flow_o));
    assert_rts_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_rts_en |=> !flow_o);
endmodule

// File: rtl/fc_cts_ctrl.sv
// CTS handling: edge-detects the selected line, keeps a sticky interrupt flag,
// and requests a transmit pause at the next character boundary.
// Assumes cts_line is already synchronous and tx_idle is high between characters.
module fc_cts_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_cts_en,
    input  logic irq_en,
    input  logic irq_clr,
    input  logic cts_line,
    input  logic tx_idle,
    output logic irq_o,
    output logic pause_o
);
    logic cts_q, irq_q, pause_q, rise;

    // Rising edge of the selected line against its last sampled value.
    always_comb rise = cts_line && !cts_q;

    // Line history, sticky interrupt and pause request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cts_q   <= 1'b0;
            irq_q   <= 1'b0;
            pause_q <= 1'b0;
        end else begin
            cts_q   <= cts_line;
            irq_q   <= (irq_q && !irq_clr) || (rise && auto_cts_en && irq_en);
            pause_q <= auto_cts_en && cts_line && (pause_q || tx_idle);
        end
    end

    assign irq_o   = irq_q;
    assign pause_o = pause_q;

    assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && auto_cts_en && irq_en) |=> irq_o);
    assert_pause_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cts_line |=> !pause_o);
    assert_pause_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_cts_en |=> !pause_o);
endmodule

// File: rtl/fc_threshold_ctrl.sv
// Top of the FIFO threshold and flow-control controller. Selects levels,
// drives the trigger flags, the flow pin (RTS or DTR), the CTS pause and
// interrupt, and the flush strobe. FIFO storage lives elsewhere.
module fc_threshold_ctrl
    import uart_fc_pkg::*;
#(
    parameter int LEG_DEPTH = 32,
    parameter int EXT_DEPTH = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FC_W-1:0]     rx_count,
    input  logic [FC_W-1:0]     tx_count,
    input  logic                fifo_en,
    input  logic [1:0]          rx_sel,
    input  logic [1:0]          tx_sel,
    input  logic [FC_W-1:0]     tx_lvl,
    input  logic [FC_W-1:0]     rx_lvl,
    input  logic [FC_W-1:0]     flow_hi,
    input  logic [FC_W-1:0]     flow_lo,
    input  logic                auto_rts_en,
    input  logic                auto_cts_en,
    input  logic                cts_irq_en,
    input  logic                cts_irq_clr,
    input  logic                pin_remap,
    input  logic                cts_i,
    input  logic                dsr_i,
    input  logic                tx_idle_i,
    output logic                rx_trig_o,
    output logic                tx_trig_o,
    output logic                rts_o,
    output logic                dtr_o,
    output logic                tx_pause_o,
    output logic                cts_irq_o,
    output logic                flush_o,
    output logic                rx_full_o
);
    logic    ext_mode, flow_line, cts_line;
    levels_t lv;
    lvl_t    depth;

    fc_level_sel #(.LEG_DEPTH(LEG_DEPTH), .EXT_DEPTH(EXT_DEPTH)) u_sel (
        .rx_sel(rx_sel), .tx_sel(tx_sel), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
        .flow_hi(flow_hi), .flow_lo(flow_lo),
        .ext_mode(ext_mode), .lv(lv), .depth(depth)
    );

    fc_flush_gen u_flush (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ext_mode(ext_mode),
        .flush_o(flush_o)
    );

    fc_rts_ctrl u_rts (
        .clk(clk), .rst_n(rst_n), .auto_rts_en(auto_rts_en),
        .rx_count(rx_count), .mark_hi(lv.flow_hi), .mark_lo(lv.flow_lo),
        .flow_o(flow_line)
    );

    // Pin remap: choose the CTS source.
    always_comb cts_line = pin_remap ? dsr_i : cts_i;

    fc_cts_ctrl u_cts (
        .clk(clk), .rst_n(rst_n), .auto_cts_en(auto_cts_en),
        .irq_en(cts_irq_en), .irq_clr(cts_irq_clr), .cts_line(cts_line),
        .tx_idle(tx_idle_i), .irq_o(cts_irq_o), .pause_o(tx_pause_o)
    );

    // Trigger flags, full flag and flow-pin steering.
    always_comb begin
        rx_trig_o = (rx_count >= lv.rx_trig);
        tx_trig_o = (tx_count <= lv.tx_trig);
        rx_full_o = (rx_count == depth);
        rts_o     = pin_remap ? 1'b0 : flow_line;
        dtr_o     = pin_remap ? flow_line : 1'b0;
    end

    assert_remap_idle_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rts_o && dtr_o));
endmodule

// File: tb/sim_fc_threshold_ctrl.sv
module sim_fc_threshold_ctrl;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] rx_count = 0, tx_count = 0, tx_lvl = 0, rx_lvl = 0, flow_hi = 0, flow_lo = 0;
    logic [1:0] rx_sel = 0, tx_sel = 0;
    logic fifo_en = 0, auto_rts_en = 0, auto_cts_en = 0, cts_irq_en = 0, cts_irq_clr = 0;
    logic pin_remap = 0, cts_i = 0, dsr_i = 0, tx_idle_i = 0;
    logic rx_trig_o, tx_trig_o, rts_o, dtr_o, tx_pause_o, cts_irq_o, flush_o, rx_full_o;

    int checks = 0, failures = 0;
    int rxt[4] = '{8, 16, 24, 28};
    int txt[4] = '{16, 8, 24, 30};
    int lot[4] = '{0, 7, 15, 23};

    // reference model state
    bit m_flow = 0, m_pause = 0, m_irq = 0, m_flush = 0, m_en = 0, m_ext = 0, m_cts = 0;

    always #10 clk = ~clk;

    fc_threshold_ctrl u0 (.*);

    function automatic bit f_ext();
        return (tx_lvl != 0) || (rx_lvl != 0) || (flow_hi != 0) || (flow_lo != 0);
    endfunction
    function automatic int f_rxl(); return f_ext() ? int'(rx_lvl) : rxt[rx_sel]; endfunction
    function automatic int f_txl(); return f_ext() ? int'(tx_lvl) : txt[tx_sel]; endfunction
    function automatic int f_hi();  return f_ext() ? int'(flow_hi) : rxt[rx_sel]; endfunction
    function automatic int f_lo();  return f_ext() ? int'(flow_lo) : lot[rx_sel]; endfunction

    // model advance on the rising edge
    always @(posedge clk) begin
        bit line;
        line = pin_remap ? dsr_i : cts_i;
        if (!rst_n) begin
            m_flow <= 0; m_pause <= 0; m_irq <= 0; m_flush <= 0; m_en <= 0; m_ext <= 0; m_cts <= 0;
        end else begin
            if (!auto_rts_en) m_flow <= 0;
            else if (int'(rx_count) >= f_hi()) m_flow <= 1;
            else if (int'(rx_count) <= f_lo()) m_flow <= 0;
            m_flush <= (fifo_en != m_en) || (f_ext() != m_ext);
            m_en <= fifo_en;
            m_ext <= f_ext();
            m_irq <= (m_irq && !cts_irq_clr) || (line && !m_cts && auto_cts_en && cts_irq_en);
            m_pause <= auto_cts_en && line && (m_pause || tx_idle_i);
            m_cts <= line;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison on the falling edge
    always @(negedge clk) if (rst_n) begin
        chk(f_ext() ? "R1 rx_trig" : "R2 rx_trig", rx_trig_o, int'(int'(rx_count) >= f_rxl()));
        chk(f_ext() ? "R1 tx_trig" : "R2 tx_trig", tx_trig_o, int'(int'(tx_count) <= f_txl()));
        chk("R7 rx_full", rx_full_o, int'(int'(rx_count) == (f_ext() ? 128 : 32)));
        chk(pin_remap ? "R8 rts" : (f_ext() ? "R4 rts" : "R3 rts"), rts_o, pin_remap ? 0 : m_flow);
        chk(pin_remap ? "R8 dtr" : "R3 dtr", dtr_o, pin_remap ? m_flow : 0);
        chk("R6 pause", tx_pause_o, m_pause);
        chk("R6 irq", cts_irq_o, m_irq);
        chk("R5 flush", flush_o, m_flush);
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sweep rx_count up then down one per cycle
    task automatic sweep(input int top);
        for (int i = 0; i <= top; i++) begin rx_count = 8'(i); step(1); end
        for (int i = top; i >= 0; i--) begin rx_count = 8'(i); step(1); end
    endtask

    initial begin
        fork
            begin #3000000; failures++; checks++; $display("FAIL watchdog timeout"); end
        join_none
        step(3);
        rst_n = 1;
        @(negedge clk);
        chk("R11 reset rts", rts_o, 0); chk("R11 reset pause", tx_pause_o, 0);
        chk("R11 reset irq", cts_irq_o, 0); chk("R11 reset flush", flush_o, 0);

        // legacy thresholds and hysteresis, every select code
        auto_rts_en = 1;
        for (int s = 0; s < 4; s++) begin
            rx_sel = 2'(s); tx_sel = 2'(s);
            for (int t = 0; t <= 32; t++) begin tx_count = 8'(t); step(1); end
            sweep(32);
        end
        rx_sel = 1; rx_count = 16; step(1);
        chk("R10 rx_trig at level", rx_trig_o, 1);
        tx_sel = 3; tx_count = 30; step(1);
        chk("R10 tx_trig at level", tx_trig_o, 1);
        tx_count = 31; step(1);
        chk("R2 tx_trig above level", tx_trig_o, 0);
        rx_count = 0; step(2);

        // extended mode: entry flushes
        flow_hi = 20; flow_lo = 10; rx_lvl = 12; tx_lvl = 100;
        step(1);
        chk("R5 flush on mode entry", flush_o, 1);
        step(1);
        chk("R5 flush one cycle", flush_o, 0);
        for (int t = 95; t <= 105; t++) begin tx_count = 8'(t); step(1); end
        sweep(128);
        flow_hi = 128; flow_lo = 1; rx_lvl = 128; tx_lvl = 1;
        sweep(128);
        rx_count = 128; step(1);
        chk("R7 full at 128", rx_full_o, 1);
        rx_count = 0; step(1);
        tx_lvl = 0; rx_lvl = 0; flow_hi = 0; flow_lo = 0; step(2);

        // fifo enable toggles
        fifo_en = 1; step(3); fifo_en = 0; step(1); fifo_en = 1; step(1); fifo_en = 0; step(3);

        // auto RTS disabled, CTS still works: independence
        auto_rts_en = 0; auto_cts_en = 1; cts_irq_en = 1;
        rx_count = 30; step(2);
        chk("R9 rts held low when disabled", rts_o, 0);
        cts_i = 1; tx_idle_i = 0; step(3);
        chk("R6 irq set", cts_irq_o, 1);
        chk("R6 pause waits for boundary", tx_pause_o, 0);
        tx_idle_i = 1; step(1); tx_idle_i = 0; step(1);
        chk("R6 pause after stop bit", tx_pause_o, 1);
        step(2);
        cts_i = 0; step(2);
        chk("R6 pause released", tx_pause_o, 0);
        cts_irq_clr = 1; step(1); cts_irq_clr = 0; step(1);
        chk("R6 irq cleared", cts_irq_o, 0);

        // auto CTS disabled, RTS enabled
        auto_cts_en = 0; auto_rts_en = 1; tx_idle_i = 1;
        cts_i = 1; step(3);
        chk("R9 no pause when cts disabled", tx_pause_o, 0);
        chk("R9 no irq when cts disabled", cts_irq_o, 0);
        cts_i = 0; step(1);

        // remap to DSR/DTR
        auto_cts_en = 1; pin_remap = 1; rx_sel = 0;
        rx_count = 9; step(2);
        chk("R8 dtr carries flow", dtr_o, 1);
        chk("R8 rts idle", rts_o, 0);
        cts_i = 1; step(2);
        chk("R8 cts ignored under remap", tx_pause_o, 0);
        dsr_i = 1; step(2);
        chk("R8 dsr pauses", tx_pause_o, 1);
        dsr_i = 0; cts_i = 0; rx_count = 0; step(2);
        pin_remap = 0; step(2);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule